// File: doc/BRIEF.md
# Vector index sequence generator

This block takes one 32-bit vector instruction word from the index-generation class. It fills a destination vector image with an arithmetic progression: lane i receives start + i × step, reduced to the element width. Start and step each come either from a sign-extended 5-bit field of the instruction or from one of two 64-bit scalar values that the surrounding pipeline presents on input ports. The element width is 8, 16, 32 or 64 bits. The vector length in bytes is a parameter, a multiple of 16 and at least 16.

An operation begins when `start` is high while the block is idle. The block then writes one lane per clock, keeping a running sum so that it needs no multiplier, and pulses `done` once the whole vector is ready. A word that does not belong to the class raises `illegal` for one cycle and leaves the vector untouched. Register-file access and permission checks belong to the surrounding pipeline.

Top module: `idxgen_top`

## Requirements
- R1: A word is accepted only when bits 31:24 equal 8'h04, bit 21 is 1 and bits 15:12 equal 4'b0100. When `start` is high in an idle cycle with any other word, `illegal` is high in the next cycle, `busy` stays low and `resultVec` keeps its value.
- R2: Bits 11:10 select the operand sources. Bit 10 set takes the start from `startOperand`, bit 10 clear takes it from the immediate in bits 9:5. Bit 11 set takes the step from `incrOperand`, bit 11 clear takes it from the immediate in bits 20:16. This gives 00 = both immediate, 01 = register start, 10 = register step, 11 = both register.
- R3: Bits 23:22 give the element size code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). The vector holds VLEN_BYTES / (element bytes) lanes. Lane i occupies bytes i×(element bytes) upward, so lane 0 sits in the lowest bytes.
- R4: The 5-bit immediates are two's-complement values and are sign-extended before use.
- R5: Every lane equals (start + i × step) modulo 2^(element bits). Overflow wraps silently.
- R6: For element sizes below 64 bits, only the low 32 bits of the scalar operands affect the result.
- R7: `busy` rises in the cycle after an accepted start. For an operation of n lanes, `done` is high for exactly one cycle, n+1 clock edges after the edge that accepted the start. `busy` falls together with that pulse.
- R8: `destReg` shows bits 4:0 of the accepted word from the cycle after acceptance until the next accepted word.
- R9: `start` has no effect while `busy` is high. The ongoing result, its timing and `destReg` are unchanged.
- R10: After reset, `busy`, `done` and `illegal` are low, and `destReg` and `resultVec` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to decode `insnWord` and begin, taken when idle |
| insnWord | input | 32 | Instruction word |
| startOperand | input | 64 | Scalar value used as start in register-start forms |
| incrOperand | input | 64 | Scalar value used as step in register-step forms |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result vector complete |
| illegal | output | 1 | One-cycle pulse: rejected instruction word |
| destReg | output | 5 | Destination register index of the accepted word |
| resultVec | output | VLEN_BYTES*8 | Result vector image, lane 0 in the low bits |

## Verification
A corrupted accumulator or step register shows as a wrong byte in `resultVec` on the clock edge that writes that lane, and the reference model catches it at the next comparison. A wrong lane counter or size register writes bytes into the wrong place or moves the `done` pulse, and `busy` or `done` then differs from the model within one cycle. A wrong decode sends an operation down the wrong path, which shows in `illegal` or `busy` on the very next cycle.

// File: rtl/idxgen_pkg.sv
package idxgen_pkg;

  localparam logic [7:0] CLASS_TOP = 8'h04;
  localparam logic [3:0] GROUP_MID = 4'b0100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;      // capture start/step operands
    logic       step;      // write current lane, advance sum
    logic [1:0] elemSize;  // size code of the running operation
  } ctrlStrobes_t;

endpackage

// File: rtl/idxgen_ctrl.sv
module idxgen_ctrl
  import idxgen_pkg::*;
#(
  parameter int VLEN_BYTES = 32,
  parameter int LANE_W     = $clog2(VLEN_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        classTop,
  input  logic [1:0]        sizeField,
  input  logic              fixedBit,
  input  logic [3:0]        groupMid,
  input  logic [4:0]        destField,
  output ctrlStrobes_t      strb,
  output logic [LANE_W-1:0] laneIdx,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [4:0]        destReg
);

  ctrlState_t        state;
  logic [1:0]        sizeReg;
  logic [LANE_W-1:0] lastLane;
  logic              wordMatch;

  always_comb begin
    wordMatch = (classTop == CLASS_TOP) && fixedBit && (groupMid == GROUP_MID);
    lastLane  = LANE_W'((VLEN_BYTES >> sizeReg) - 1);
  end

  always_comb begin
    strb.load     = start && (state == ST_IDLE) && wordMatch;
    strb.step     = (state == ST_RUN);
    strb.elemSize = sizeReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      laneIdx <= '0;
      sizeReg <= '0;
      destReg <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (wordMatch) begin
              state   <= ST_RUN;
              laneIdx <= '0;
              sizeReg <= sizeField;
              destReg <= destField;
            end else begin
              illegal <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (laneIdx == lastLane) begin
            state <= ST_FIN;
          end else begin
            laneIdx <= laneIdx + 1'b1;
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/idxgen_dp.sv
module idxgen_dp
  import idxgen_pkg::*;
#(
  parameter int VLEN_BYTES = 32,
  parameter int LANE_W     = $clog2(VLEN_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strb,
  input  logic [LANE_W-1:0]       laneIdx,
  input  logic [1:0]              formField,
  input  logic [4:0]              startImm,
  input  logic [4:0]              incrImm,
  input  logic [63:0]             startReg,
  input  logic [63:0]             incrReg,
  output logic [VLEN_BYTES*8-1:0] resultVec
);

  logic [63:0] startSel;
  logic [63:0] incrSel;
  logic [63:0] accSum;
  logic [63:0] incrHeld;

  always_comb begin
    startSel = formField[0] ? startReg : {{59{startImm[4]}}, startImm};
    incrSel  = formField[1] ? incrReg  : {{59{incrImm[4]}},  incrImm};
  end

  // running sum replaces lane * step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accSum   <= '0;
      incrHeld <= '0;
    end else if (strb.load) begin
      accSum   <= startSel;
      incrHeld <= incrSel;
    end else if (strb.step) begin
      accSum   <= accSum + incrHeld;
    end
  end

  logic [7:0] vecBytes [VLEN_BYTES];

  for (genvar b = 0; b < VLEN_BYTES; b++) begin : g_byte
    logic       wrEn;
    logic [7:0] byteData;

    always_comb begin
      unique case (strb.elemSize)
        2'd0: begin
          wrEn     = (laneIdx == LANE_W'(b));
          byteData = accSum[7:0];
        end
        2'd1: begin
          wrEn     = (laneIdx == LANE_W'(b >> 1));
          byteData = accSum[8*(b%2) +: 8];
        end
        2'd2: begin
          wrEn     = (laneIdx == LANE_W'(b >> 2));
          byteData = accSum[8*(b%4) +: 8];
        end
        default: begin
          wrEn     = (laneIdx == LANE_W'(b >> 3));
          byteData = accSum[8*(b%8) +: 8];
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecBytes[b] <= '0;
      end else if (strb.step && wrEn) begin
        vecBytes[b] <= byteData;
      end
    end

    assign resultVec[8*b +: 8] = vecBytes[b];
  end

endmodule

// File: rtl/idxgen_top.sv
module idxgen_top
  import idxgen_pkg::*;
#(
  parameter int VLEN_BYTES = 32,
  localparam int LANE_W    = $clog2(VLEN_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [31:0]             insnWord,
  input  logic [63:0]             startOperand,
  input  logic [63:0]             incrOperand,
  output logic                    busy,
  output logic                    done,
  output logic                    illegal,
  output logic [4:0]              destReg,
  output logic [VLEN_BYTES*8-1:0] resultVec
);

  ctrlStrobes_t      strb;
  logic [LANE_W-1:0] laneIdx;

  idxgen_ctrl #(.VLEN_BYTES(VLEN_BYTES), .LANE_W(LANE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .classTop  (insnWord[31:24]),
    .sizeField (insnWord[23:22]),
    .fixedBit  (insnWord[21]),
    .groupMid  (insnWord[15:12]),
    .destField (insnWord[4:0]),
    .strb      (strb),
    .laneIdx   (laneIdx),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .destReg   (destReg)
  );

  idxgen_dp #(.VLEN_BYTES(VLEN_BYTES), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .laneIdx   (laneIdx),
    .formField (insnWord[11:10]),
    .startImm  (insnWord[9:5]),
    .incrImm   (insnWord[20:16]),
    .startReg  (startOperand),
    .incrReg   (incrOperand),
    .resultVec (resultVec)
  );

endmodule

// File: rtl/idxgen_chk.sv
module idxgen_chk #(
  parameter int VLEN_BYTES = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic [7:0]              classTop,
  input logic                    fixedBit,
  input logic [3:0]              groupMid,
  input logic [4:0]              destField,
  input logic                    busy,
  input logic                    done,
  input logic                    illegal,
  input logic [4:0]              destReg,
  input logic [VLEN_BYTES*8-1:0] resultVec
);

  logic wordOk;
  assign wordOk = (classTop == 8'h04) && fixedBit && (groupMid == 4'b0100);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && wordOk) |=> (busy && !illegal));

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !wordOk) |=> (illegal && !busy));

  assert_reject_keeps_R1: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(resultVec));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(resultVec));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  assert_dest_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && wordOk) |=> (destReg == $past(destField)));

endmodule

bind idxgen_top idxgen_chk #(.VLEN_BYTES(VLEN_BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .classTop  (insnWord[31:24]),
  .fixedBit  (insnWord[21]),
  .groupMid  (insnWord[15:12]),
  .destField (insnWord[4:0]),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .destReg   (destReg),
  .resultVec (resultVec)
);

// File: tb/sim_idxgen_top.sv
module sim_idxgen_top;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN       = 32;
  localparam int VW         = VLEN * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   insnWord = '0;
  logic [63:0]   startOperand = '0;
  logic [63:0]   incrOperand = '0;
  logic          busy, done, illegal;
  logic [4:0]    destReg;
  logic [VW-1:0] resultVec;

  idxgen_top #(.VLEN_BYTES(VLEN)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .insnWord(insnWord),
    .startOperand(startOperand), .incrOperand(incrOperand),
    .busy(busy), .done(done), .illegal(illegal),
    .destReg(destReg), .resultVec(resultVec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string curTag = "R10";
  bit    liveCompare = 1'b0;

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int            mPhase = 0;
  int            mLane = 0;
  int            mLanes = 0;
  int            mSz = 0;
  logic [63:0]   mS = '0, mI = '0;
  logic [VW-1:0] mVec = '0;
  logic          mBusy = 0, mDone = 0, mIll = 0;
  logic [4:0]    mDest = '0;

  function automatic logic [63:0] sx5(logic [4:0] f);
    return {{59{f[4]}}, f};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mVec = '0; mBusy = 0; mDone = 0; mIll = 0; mDest = '0;
    end else begin
      mDone = 0; mIll = 0;
      if (mPhase == 0) begin
        if (start) begin
          if (insnWord[31:24] == 8'h04 && insnWord[21] && insnWord[15:12] == 4'b0100) begin
            mPhase = 1; mLane = 0;
            mSz = int'(insnWord[23:22]);
            mLanes = VLEN / (1 << mSz);
            mS = insnWord[10] ? startOperand : sx5(insnWord[9:5]);
            mI = insnWord[11] ? incrOperand : sx5(insnWord[20:16]);
            mDest = insnWord[4:0];
          end else begin
            mIll = 1;
          end
        end
      end else if (mPhase == 1) begin
        logic [63:0] e;
        e = mS + 64'(mLane) * mI;
        for (int k = 0; k < 8; k++)
          if (k < (1 << mSz)) mVec[((mLane << mSz) + k) * 8 +: 8] = e[8*k +: 8];
        mLane++;
        if (mLane == mLanes) mPhase = 2;
      end else begin
        mPhase = 0; mDone = 1;
      end
      mBusy = (mPhase != 0);
    end
  end

  always @(negedge clk) begin
    if (liveCompare) begin
      chk("R7 busy", VW'(busy), VW'(mBusy));
      chk("R7 done", VW'(done), VW'(mDone));
      chk("R1 illegal", VW'(illegal), VW'(mIll));
      chk("R8 destReg", VW'(destReg), VW'(mDest));
      chk(curTag, resultVec, mVec);
    end
  end

  function automatic logic [31:0] mk(logic [1:0] sz, logic [1:0] form,
                                     logic [4:0] incF, logic [4:0] stF, logic [4:0] rd);
    return {8'h04, sz, 1'b1, incF, 4'b0100, form, stF, rd};
  endfunction

  task automatic issue(logic [31:0] w, logic [63:0] s, logic [63:0] i);
    @(negedge clk);
    insnWord = w; startOperand = s; incrOperand = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runOp(string tag, logic [31:0] w, logic [63:0] s, logic [63:0] i);
    curTag = tag;
    issue(w, s, i);
    repeat (VLEN + 4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL R7 watchdog act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 busy", VW'(busy), '0);
    chk("R10 done", VW'(done), '0);
    chk("R10 illegal", VW'(illegal), '0);
    chk("R10 destReg", VW'(destReg), '0);
    chk("R10 resultVec", resultVec, '0);
    rstN = 1'b1;
    liveCompare = 1'b1;
    @(negedge clk);

    // R2 and R3: every form at every element size
    for (int sz = 0; sz < 4; sz++)
      for (int fm = 0; fm < 4; fm++)
        runOp("R2 R3 form/size", mk(2'(sz), 2'(fm), 5'd7, 5'b11101, 5'(sz*4 + fm)),
              64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFD);

    // R4: negative immediates
    runOp("R4 neg imm 64", mk(2'd3, 2'b00, 5'b11111, 5'b10000, 5'd9), '0, '0);
    runOp("R4 neg imm 8", mk(2'd0, 2'b00, 5'b10001, 5'b01111, 5'd10), '0, '0);

    // R5: wraparound at element width
    runOp("R5 wrap 8", mk(2'd0, 2'b11, 5'd0, 5'd0, 5'd11), 64'h0000_0000_0000_00F0, 64'h11);
    runOp("R5 wrap 16", mk(2'd1, 2'b11, 5'd0, 5'd0, 5'd12), 64'hFFF0, 64'h1000);
    runOp("R5 wrap 64", mk(2'd3, 2'b11, 5'd0, 5'd0, 5'd13),
          64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0001);

    // R6: high operand bits with 32-bit elements
    runOp("R6 low32", mk(2'd2, 2'b11, 5'd0, 5'd0, 5'd14),
          64'hDEAD_BEEF_0000_0010, 64'h5555_5555_8000_0001);

    // R3: lane placement for 64-bit elements
    runOp("R3 placement", mk(2'd3, 2'b01, 5'd1, 5'd0, 5'd15), 64'h1, '0);

    // R1: rejected words keep the vector
    runOp("R1 bit21", mk(2'd0, 2'b00, 5'd1, 5'd1, 5'd16) & ~32'h0020_0000, '0, '0);
    runOp("R1 top byte", mk(2'd1, 2'b00, 5'd1, 5'd1, 5'd17) ^ 32'h0100_0000, '0, '0);
    runOp("R1 mid bits", mk(2'd2, 2'b00, 5'd1, 5'd1, 5'd18) ^ 32'h0000_2000, '0, '0);

    // R9: start while busy is ignored
    curTag = "R9 busy start";
    issue(mk(2'd0, 2'b00, 5'd3, 5'd1, 5'd19), '0, '0);
    repeat (3) @(negedge clk);
    issue(mk(2'd3, 2'b11, 5'd0, 5'd0, 5'd20), 64'hAAAA, 64'h5555);
    repeat (VLEN + 4) @(negedge clk);

    // back-to-back: start in the done cycle
    curTag = "R7 back to back";
    issue(mk(2'd2, 2'b10, 5'd0, 5'd4, 5'd21), '0, 64'hFFFF_FFF8);
    repeat (VLEN / 4) @(negedge clk);
    issue(mk(2'd1, 2'b01, 5'd2, 5'd0, 5'd22), 64'h7FFE, '0);
    repeat (VLEN + 4) @(negedge clk);

    liveCompare = 1'b0;
    summary();
    $finish;
  end

endmodule